// File: doc/BRIEF.md
# Crystal Trim Frequency-Offset Tracking Controller

This block steers a 6-bit crystal capacitance trim code so that the carrier frequency offset seen by the receiver moves toward zero. Every received packet may carry a signed offset sample for each receive path. The block keeps a running sum and a sample count per path, but only for packets addressed by the connected peer, and it counts the packets it accepts.

A periodic tick starts one tracking pass. If the link is down or more than one peer is active, the trim code takes one step toward a supplied default. If no new packet has arrived since the last pass, nothing changes. Otherwise the per-path sums are converted to kHz by a fixed-point multiply and divided by their counts in a small sequential divider. The results are averaged across the paths that have samples, and the average then drives four decisions in turn: a one-shot glitch filter, an adjust-start/adjust-stop hysteresis, a one-step trim move with saturation, and an automatic-tracking enable with its own threshold. A coexistence flag forces the default trim code and stops adjustment. A one-cycle done pulse marks the cycle in which the outputs take their new values.

Top module: `cfo_trim_tracker`

## Requirements
- R1: After reset, `trim_word` equals `trim_default` in both its low 6 bits [5:0] and its high 6 bits [11:6], and `auto_track` is 1. The two halves always carry the same code.
- R2: A packet is accumulated only when `smp_valid` and `smp_match` are both 1. Its stream count is clamped to CFG_PATHS, and only paths 0 up to the clamped count minus 1 take their sample (path p uses `smp_data[8p+7:8p]`, two's complement).
- R3: On a tick with `link_up`=0 or `single_peer`=0, the trim code moves one step toward `trim_default` (it does not move when equal), adjustment is armed, `auto_track` becomes 1, and `tick_done` pulses one cycle after the tick.
- R4: On a tick with no packet accepted since the previous processed tick, the outputs keep their values and `tick_done` pulses one cycle after the tick.
- R5: Each path with a nonzero count contributes (|sum|·KHZ_MUL >> KHZ_SHIFT)/count, with the sign of the sum. With two or more contributing paths, the average is their sum divided by their number, truncated toward zero. Sums and counts restart from zero at each processed tick.
- R6: When the new average differs from the previous accepted average by more than JUMP_LIM, no hit is pending, and adjustment is not armed, the tick only records a hit and the outputs keep their values. The next processed tick clears the hit and is handled normally.
- R7: While not armed, adjustment arms when |average| > TH_HIGH. While armed, it disarms when |average| < TH_LOW.
- R8: While armed (after R7), the trim code rises by 1 when average > TH_LOW, falls by 1 when average < −TH_LOW, and otherwise holds.
- R9: The trim code saturates at 63 and at 0.
- R10: When `coex_active` is 1 on a processed tick, the trim code is set to `trim_default` and adjustment is disarmed.
- R11: On a processed tick, `auto_track` becomes 0 when |average| < TH_TRACK and 1 otherwise. While `trk_bypass` is 1, a processed tick leaves it unchanged.
- R12: `tick_done` is a single-cycle pulse for each tick. The trim code changes only in a cycle where `tick_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A packet's offset samples are present |
| smp_match | input | 1 | The packet is addressed by the connected peer |
| smp_streams | input | 3 | Number of streams carried by the packet |
| smp_data | input | 32 | Signed 8-bit sample per path, path 0 in the low byte |
| tick | input | 1 | Starts one tracking pass |
| link_up | input | 1 | A link is established |
| single_peer | input | 1 | Exactly one peer is associated |
| coex_active | input | 1 | A coexisting radio is active; tracking is suspended |
| trk_bypass | input | 1 | Leave the automatic-tracking enable unchanged |
| trim_default | input | 6 | Default trim code |
| trim_word | output | 12 | Trim code, duplicated into two 6-bit fields |
| auto_track | output | 1 | Automatic tracking enable |
| tick_done | output | 1 | One-cycle pulse when a pass has finished |

## Verification
For ticks that take the link-down path or find no new packet, outputs are due exactly one cycle after the tick. The bench measures that latency and checks that it is 1. A processing tick passes through up to five sequential divisions, so its latency depends on how many paths hold samples. For those ticks the bench waits for `tick_done` and samples `trim_word` and `auto_track` on the falling edge where the pulse is high, because the outputs and the pulse are written on the same edge. It then checks that the pulse has dropped one cycle later. Inputs change on falling edges, and samples are driven at least one idle cycle before each tick.

// File: rtl/cfo_trk_pkg.sv
package cfo_trk_pkg;

    localparam int CAP_W   = 6;
    localparam int CAP_MAX = (1 << CAP_W) - 1;

    typedef logic [CAP_W-1:0] cap_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PATH,
        ST_WAIT,
        ST_AVG,
        ST_AVGW,
        ST_DECIDE
    } trk_state_e;

    typedef struct packed {
        logic hit;
        logic armed;
        logic auto_on;
    } trk_flags_t;

    function automatic cap_t cap_toward(cap_t cur, cap_t tgt);
        if (cur < tgt)      return cur + cap_t'(1);
        else if (cur > tgt) return cur - cap_t'(1);
        else                return cur;
    endfunction

    function automatic cap_t cap_nudge(cap_t cur, logic up, logic dn);
        if (up && cur != cap_t'(CAP_MAX)) return cur + cap_t'(1);
        if (dn && cur != cap_t'(0))       return cur - cap_t'(1);
        return cur;
    endfunction

endpackage

// File: rtl/cfo_seq_div.sv
module cfo_seq_div #(
    parameter int W = 24,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    logic [W-1:0]  rem_q, quo_q, dsr_q;
    logic [CW-1:0] left_q;
    logic [W:0]    trial, sub;

    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        sub   = trial - {1'b0, dsr_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dsr_q  <= '0;
            left_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dsr_q  <= divisor;
                left_q <= CW'(W);
            end else if (left_q != '0) begin
                if (trial >= {1'b0, dsr_q}) begin
                    rem_q <= sub[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                left_q <= left_q - CW'(1);
                if (left_q == CW'(1)) done <= 1'b1;
            end
        end
    end

    assign quotient = quo_q;
endmodule

// File: rtl/cfo_path_accum.sv
module cfo_path_accum #(
    parameter int NPATH     = 4,
    parameter int CFG_PATHS = 3,
    parameter int SMP_W     = 8,
    parameter int CNT_W     = 8,
    parameter int PKT_W     = 16,
    localparam int SUM_W    = SMP_W + CNT_W,
    localparam int SC_W     = $clog2(NPATH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_valid,
    input  logic                   smp_match,
    input  logic [SC_W-1:0]        smp_streams,
    input  logic [NPATH*SMP_W-1:0] smp_data,
    input  logic                   clr,
    output logic [NPATH*SUM_W-1:0] sums,
    output logic [NPATH*CNT_W-1:0] cnts,
    output logic [PKT_W-1:0]       pkt_cnt
);
    logic [SC_W-1:0] eff_streams;
    logic            accept;

    always_comb begin
        eff_streams = (smp_streams > SC_W'(CFG_PATHS)) ? SC_W'(CFG_PATHS) : smp_streams;
        accept      = smp_valid && smp_match;
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        logic signed [SMP_W-1:0] smp;
        logic signed [SUM_W-1:0] ext, sum_q;
        logic [CNT_W-1:0]        cnt_q;
        logic                    take;

        always_comb begin
            smp  = smp_data[p*SMP_W +: SMP_W];
            ext  = {{(SUM_W-SMP_W){smp[SMP_W-1]}}, smp};
            take = accept && (SC_W'(p) < eff_streams);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sum_q <= '0;
                cnt_q <= '0;
            end else if (clr || take) begin
                sum_q <= (clr ? '0 : sum_q) + (take ? ext : '0);
                cnt_q <= (clr ? '0 : cnt_q) + CNT_W'(take);
            end
        end

        assign sums[p*SUM_W +: SUM_W] = sum_q;
        assign cnts[p*CNT_W +: CNT_W] = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         pkt_cnt <= '0;
        else if (accept) pkt_cnt <= pkt_cnt + PKT_W'(1);
    end
endmodule

// File: rtl/cfo_trim_tracker.sv
module cfo_trim_tracker
    import cfo_trk_pkg::*;
#(
    parameter int NPATH     = 4,
    parameter int CFG_PATHS = 3,
    parameter int SMP_W     = 8,
    parameter int CNT_W     = 8,
    parameter int PKT_W     = 16,
    parameter int DIV_W     = 24,
    parameter int KHZ_MUL   = 25,
    parameter int KHZ_SHIFT = 1,
    parameter int TH_HIGH   = 20,
    parameter int TH_LOW    = 10,
    parameter int TH_TRACK  = 80,
    parameter int JUMP_LIM  = 20,
    localparam int SC_W     = $clog2(NPATH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_valid,
    input  logic                   smp_match,
    input  logic [SC_W-1:0]        smp_streams,
    input  logic [NPATH*SMP_W-1:0] smp_data,
    input  logic                   tick,
    input  logic                   link_up,
    input  logic                   single_peer,
    input  logic                   coex_active,
    input  logic                   trk_bypass,
    input  logic [CAP_W-1:0]       trim_default,
    output logic [2*CAP_W-1:0]     trim_word,
    output logic                   auto_track,
    output logic                   tick_done
);
    localparam int SUM_W = SMP_W + CNT_W;
    localparam int PI_W  = (NPATH > 1) ? $clog2(NPATH) : 1;
    localparam int NV_W  = $clog2(NPATH + 1);
    localparam int AVG_W = DIV_W + 2;
    localparam int PRD_W = DIV_W + 8;
    localparam logic signed [AVG_W-1:0] HI_S  = AVG_W'(TH_HIGH);
    localparam logic signed [AVG_W-1:0] LO_S  = AVG_W'(TH_LOW);
    localparam logic signed [AVG_W-1:0] TRK_S = AVG_W'(TH_TRACK);
    localparam logic signed [AVG_W-1:0] JMP_S = AVG_W'(JUMP_LIM);

    trk_state_e state;
    trk_flags_t flags;
    cap_t       trim_q;

    logic [NPATH*SUM_W-1:0] acc_sums;
    logic [NPATH*CNT_W-1:0] acc_cnts;
    logic [PKT_W-1:0]       pkt_cnt, pkt_seen;
    logic                   acc_clr, fsm_busy, link_ok;

    logic signed [SUM_W-1:0] snap_sum [NPATH];
    logic [CNT_W-1:0]        snap_cnt [NPATH];
    logic [PI_W-1:0]         pidx;
    logic [NV_W-1:0]         nvalid;
    logic signed [AVG_W-1:0] total, avg, prev_avg;

    logic                   div_start, div_done;
    logic [DIV_W-1:0]       div_a, div_b, div_q;

    cfo_path_accum #(
        .NPATH(NPATH), .CFG_PATHS(CFG_PATHS), .SMP_W(SMP_W),
        .CNT_W(CNT_W), .PKT_W(PKT_W)
    ) u_accum (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_match(smp_match),
        .smp_streams(smp_streams), .smp_data(smp_data), .clr(acc_clr),
        .sums(acc_sums), .cnts(acc_cnts), .pkt_cnt(pkt_cnt)
    );

    cfo_seq_div #(.W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .dividend(div_a),
        .divisor(div_b), .done(div_done), .quotient(div_q)
    );

    // Per-path magnitude conversion to kHz
    logic signed [SUM_W-1:0] sel_sum;
    logic                    sel_neg, last_path;
    logic [SUM_W-1:0]        sel_mag;
    logic [PRD_W-1:0]        prod, prod_sh;
    logic [DIV_W-1:0]        khz_mag;
    logic signed [AVG_W-1:0] q_ext, total_abs;

    always_comb begin
        sel_sum   = snap_sum[pidx];
        sel_neg   = sel_sum[SUM_W-1];
        sel_mag   = sel_neg ? SUM_W'(-sel_sum) : SUM_W'(sel_sum);
        prod      = PRD_W'(sel_mag) * PRD_W'(KHZ_MUL);
        prod_sh   = prod >> KHZ_SHIFT;
        khz_mag   = prod_sh[DIV_W-1:0];
        q_ext     = {2'b00, div_q};
        total_abs = (total < 0) ? -total : total;
        last_path = (pidx == PI_W'(NPATH - 1));
        link_ok   = link_up && single_peer;
        fsm_busy  = (state != ST_IDLE);
        acc_clr   = (state == ST_IDLE) && tick && link_ok && (pkt_cnt != pkt_seen);
    end

    always_comb begin
        div_start = 1'b0;
        div_a     = khz_mag;
        div_b     = DIV_W'(snap_cnt[pidx]);
        case (state)
            ST_PATH: div_start = (snap_cnt[pidx] != '0);
            ST_AVG: begin
                div_start = (nvalid >= NV_W'(2));
                div_a     = total_abs[DIV_W-1:0];
                div_b     = DIV_W'(nvalid);
            end
            default: ;
        endcase
    end

    // Decision stage
    logic signed [AVG_W-1:0] jump_d, jump_abs;
    logic                    jump_hit;
    trk_flags_t              flags_n;
    cap_t                    trim_n;

    always_comb begin
        jump_d   = prev_avg - avg;
        jump_abs = (jump_d < 0) ? -jump_d : jump_d;
        jump_hit = (jump_abs > JMP_S) && !flags.hit && !flags.armed;

        flags_n.hit   = 1'b0;
        flags_n.armed = flags.armed ? !((avg < LO_S) && (avg > -LO_S))
                                    : ((avg > HI_S) || (avg < -HI_S));
        trim_n = trim_q;
        if (coex_active) begin
            flags_n.armed = 1'b0;
            trim_n        = trim_default;
        end
        if (flags_n.armed)
            trim_n = cap_nudge(trim_q, avg > LO_S, avg < -LO_S);
        flags_n.auto_on = trk_bypass ? flags.auto_on
                                     : !((avg < TRK_S) && (avg > -TRK_S));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            flags    <= '{hit: 1'b0, armed: 1'b1, auto_on: 1'b1};
            trim_q   <= trim_default;
            pkt_seen <= '0;
            pidx     <= '0;
            nvalid   <= '0;
            total    <= '0;
            avg      <= '0;
            prev_avg <= '0;
            tick_done <= 1'b0;
            for (int i = 0; i < NPATH; i++) begin
                snap_sum[i] <= '0;
                snap_cnt[i] <= '0;
            end
        end else begin
            tick_done <= 1'b0;
            case (state)
                ST_IDLE: if (tick) begin
                    if (!link_ok) begin
                        trim_q        <= cap_toward(trim_q, trim_default);
                        flags.armed   <= 1'b1;
                        flags.auto_on <= 1'b1;
                        tick_done     <= 1'b1;
                    end else if (pkt_cnt == pkt_seen) begin
                        tick_done <= 1'b1;
                    end else begin
                        pkt_seen <= pkt_cnt;
                        for (int i = 0; i < NPATH; i++) begin
                            snap_sum[i] <= acc_sums[i*SUM_W +: SUM_W];
                            snap_cnt[i] <= acc_cnts[i*CNT_W +: CNT_W];
                        end
                        pidx   <= '0;
                        nvalid <= '0;
                        total  <= '0;
                        state  <= ST_PATH;
                    end
                end
                ST_PATH: begin
                    if (div_start)      state <= ST_WAIT;
                    else if (last_path) state <= ST_AVG;
                    else                pidx  <= pidx + PI_W'(1);
                end
                ST_WAIT: if (div_done) begin
                    total  <= total + (sel_neg ? -q_ext : q_ext);
                    nvalid <= nvalid + NV_W'(1);
                    if (last_path) state <= ST_AVG;
                    else begin
                        pidx  <= pidx + PI_W'(1);
                        state <= ST_PATH;
                    end
                end
                ST_AVG: begin
                    if (div_start) state <= ST_AVGW;
                    else begin
                        avg   <= total;
                        state <= ST_DECIDE;
                    end
                end
                ST_AVGW: if (div_done) begin
                    avg   <= (total < 0) ? -q_ext : q_ext;
                    state <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (jump_hit) flags.hit <= 1'b1;
                    else begin
                        flags    <= flags_n;
                        prev_avg <= avg;
                        trim_q   <= trim_n;
                    end
                    tick_done <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign trim_word  = {trim_q, trim_q};
    assign auto_track = flags.auto_on;
endmodule

// File: rtl/cfo_trim_tracker_chk.sv
module cfo_trim_tracker_chk
    import cfo_trk_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic               link_up,
    input logic               single_peer,
    input logic               coex_active,
    input logic               trk_bypass,
    input logic [2*CAP_W-1:0] trim_word,
    input logic               auto_track,
    input logic               tick_done,
    input logic               fsm_busy
);
    logic [CAP_W-1:0] lo_f, hi_f;
    assign lo_f = trim_word[CAP_W-1:0];
    assign hi_f = trim_word[2*CAP_W-1:CAP_W];

    assert_halves_R1: assert property (@(posedge clk) disable iff (rst)
        hi_f == lo_f);

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !tick_done |-> $stable(trim_word));

    assert_step_R8: assert property (@(posedge clk) disable iff (rst)
        (tick_done && !$past(coex_active)) |->
        (lo_f == $past(lo_f) || lo_f == $past(lo_f) + 6'd1 || lo_f == $past(lo_f) - 6'd1));

    assert_linkdown_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !fsm_busy && !link_up) |=> (tick_done && auto_track));

    assert_bypass_R11: assert property (@(posedge clk) disable iff (rst)
        (trk_bypass && $past(trk_bypass) && $past(link_up) && $past(single_peer))
        |-> $stable(auto_track));
endmodule

bind cfo_trim_tracker cfo_trim_tracker_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .link_up(link_up),
    .single_peer(single_peer), .coex_active(coex_active),
    .trk_bypass(trk_bypass), .trim_word(trim_word),
    .auto_track(auto_track), .tick_done(tick_done), .fsm_busy(fsm_busy)
);

// File: tb/tb_cfo_trim_tracker.sv
`timescale 1ns/1ps
module tb_cfo_trim_tracker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 0, smp_match = 0, tick = 0;
    logic [2:0]  smp_streams = '0;
    logic [31:0] smp_data = '0;
    logic        link_up = 1, single_peer = 1, coex_active = 0, trk_bypass = 0;
    logic [5:0]  trim_default = 6'h20;
    logic [11:0] trim_word;
    logic        auto_track, tick_done;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    cfo_trim_tracker dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_match(smp_match),
        .smp_streams(smp_streams), .smp_data(smp_data), .tick(tick),
        .link_up(link_up), .single_peer(single_peer), .coex_active(coex_active),
        .trk_bypass(trk_bypass), .trim_default(trim_default),
        .trim_word(trim_word), .auto_track(auto_track), .tick_done(tick_done)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int trim_of(int code);
        return (code << 6) | code;
    endfunction

    task automatic send_pkt(bit match, int streams, int s0, int s1, int s2, int s3);
        @(negedge clk);
        smp_valid   = 1;
        smp_match   = match;
        smp_streams = 3'(streams);
        smp_data    = {8'(s3), 8'(s2), 8'(s1), 8'(s0)};
        @(negedge clk);
        smp_valid = 0;
        smp_match = 0;
        @(negedge clk);
    endtask

    // Pulse tick, wait for tick_done, return latency; outputs sampled at that edge
    task automatic run_tick(output int lat);
        @(negedge clk);
        tick = 1;
        @(negedge clk);
        tick = 0;
        lat = 1;
        while (!tick_done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic tick_expect(string req, int code, int auto_exp);
        int lat;
        run_tick(lat);
        chk("R12", "done seen", int'(tick_done), 1);
        chk(req, "trim_word", int'(trim_word), trim_of(code));
        chk(req, "auto_track", int'(auto_track), auto_exp);
        @(negedge clk);
        chk("R12", "done single pulse", int'(tick_done), 0);
    endtask

    task automatic t_reset();
        chk("R1", "reset trim", int'(trim_word), trim_of(32));
        chk("R1", "reset auto", int'(auto_track), 1);
        chk("R12", "reset done", int'(tick_done), 0);
    endtask

    task automatic t_no_packet();
        int lat;
        run_tick(lat);
        chk("R4", "latency", lat, 1);
        chk("R4", "trim", int'(trim_word), trim_of(32));
    endtask

    task automatic t_single_path();
        send_pkt(1, 1, 8, 0, 0, 0);          // 100 kHz
        tick_expect("R8", 33, 1);
    endtask

    task automatic t_stop();
        send_pkt(1, 2, 6, -6, 0, 0);
        send_pkt(1, 2, 2, -2, 0, 0);          // +50, -50 -> 0
        tick_expect("R7", 33, 0);
    endtask

    task automatic t_glitch();
        send_pkt(1, 1, 8, 0, 0, 0);
        tick_expect("R6", 33, 0);             // first jump ignored
        send_pkt(1, 1, 8, 0, 0, 0);
        tick_expect("R7", 34, 1);             // accepted, arms, steps up
    endtask

    task automatic t_average();
        send_pkt(1, 2, 8, 4, 0, 0);           // (100+50)/2 = 75
        tick_expect("R5", 35, 0);
        send_pkt(1, 1, -8, 0, 0, 0);          // -100
        tick_expect("R8", 34, 1);
    endtask

    task automatic t_clamp_match();
        int lat;
        send_pkt(1, 4, 8, 8, 8, -120);        // path 3 dropped -> 100
        tick_expect("R2", 35, 1);
        send_pkt(0, 1, -8, 0, 0, 0);          // not matched
        run_tick(lat);
        chk("R2", "mismatch latency", lat, 1);
        chk("R2", "mismatch trim", int'(trim_word), trim_of(35));
    endtask

    task automatic t_bypass();
        trk_bypass = 1;
        send_pkt(1, 1, 1, 0, 0, 0);           // 12 kHz
        tick_expect("R11", 36, 1);
        trk_bypass = 0;
    endtask

    task automatic t_coex();
        coex_active = 1;
        send_pkt(1, 1, 8, 0, 0, 0);
        tick_expect("R10", 32, 1);
        coex_active = 0;
    endtask

    task automatic t_link_down();
        int lat;
        trim_default = 6'h22;
        link_up = 0;
        run_tick(lat);
        chk("R3", "latency", lat, 1);
        chk("R3", "step up", int'(trim_word), trim_of(33));
        link_up = 1;
        single_peer = 0;
        run_tick(lat);
        chk("R3", "step multi-peer", int'(trim_word), trim_of(34));
        run_tick(lat);
        chk("R3", "hold at default", int'(trim_word), trim_of(34));
        chk("R3", "auto", int'(auto_track), 1);
        single_peer = 1;
    endtask

    task automatic t_saturate();
        int lat;
        trim_default = 6'h3F;
        link_up = 0;
        for (int i = 0; i < 40; i++) run_tick(lat);
        chk("R3", "reach high default", int'(trim_word), trim_of(63));
        link_up = 1;
        send_pkt(1, 1, 8, 0, 0, 0);
        tick_expect("R9", 63, 1);
        trim_default = 6'h00;
        link_up = 0;
        for (int i = 0; i < 70; i++) run_tick(lat);
        chk("R3", "reach low default", int'(trim_word), trim_of(0));
        link_up = 1;
        send_pkt(1, 1, -8, 0, 0, 0);
        tick_expect("R9", 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_no_packet();
        t_single_path();
        t_stop();
        t_glitch();
        t_average();
        t_clamp_match();
        t_bypass();
        t_coex();
        t_link_down();
        t_saturate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule